// File: doc/BRIEF.md
# Transmit Ring Index Manager

This block keeps the index state for a transmit FIFO that is built from a ring of message-buffer slots in a CAN controller. Software places one or more frames in consecutive slots starting at the put index and then issues one add request that carries the number of slots. The transmitter reports each finished frame, and each aborted request, as a one-cycle strobe that carries a slot number.

The block tracks the get index, the put index, the count of free slots and the full and empty conditions. It keeps one pending bit per slot and presents the slot at the get index as the next frame to send. When the slot at the head of the ring finishes or is aborted, the get index moves forward past any slots whose requests were withdrawn. The block also forms the message-RAM word address of the slot at the put index. This address is a base address plus the put index times the element size in 32-bit words.

The ring depth is a parameter from 1 to 32, and all index arithmetic wraps modulo that depth. A mode input turns the FIFO behaviour off. While it is high, the block ignores every event.

Top module: `txr_index_mgr`

## Requirements
- R1: After reset the get and put indices are 0, the free level equals DEPTH, empty is 1, full is 0, the overflow flag is 0 and tx_valid is 0.
- R2: An accepted add request of n slots (1 to free level) marks slots put, put+1, ..., put+n-1 (mod DEPTH) as pending. It advances the put index by n modulo DEPTH and lowers the free level by n. All of these show on the next cycle.
- R3: The free level equals DEPTH minus the number of occupied slots. Full is 1 exactly when the free level is 0. Empty is 1 exactly when the free level is DEPTH, so the two stay distinct when the indices are equal.
- R4: tx_valid is 1 when the slot at the get index is pending and the FIFO mode is active. Slots are offered in the order they were added.
- R5: A completion strobe whose slot equals the get index and is pending clears that slot. The get index then moves to the next pending slot within the occupied region (get+1 when no request was withdrawn), and the free level rises by the distance moved. A completion for any other slot is ignored.
- R6: Cancelling the pending slot at the get index moves the get index to the next slot that is still pending within the occupied region. If no such slot exists, the get index moves to the put index. The free level rises by the distance skipped.
- R7: Cancelling a slot other than the get index clears its pending bit and leaves the get index and the free level unchanged.
- R8: An add request for more slots than the free level sets a sticky overflow flag, which only reset clears. Such a request changes no index and no pending bit.
- R9: A completion and an accepted add request in the same cycle both take effect. The next cycle shows the combined free level.
- R10: free_addr equals base_addr plus put_idx times elem_words, truncated to 16 bits.
- R11: While queue_mode is 1, add, completion and cancel strobes are ignored and tx_valid is 0.
- R12: When completion and cancel strobes arrive in the same cycle, the completion is applied and the cancel is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| queue_mode | input | 1 | 1 disables FIFO behaviour |
| add_valid | input | 1 | Add request strobe |
| add_count | input | 6 | Number of slots added (0 does nothing) |
| done_valid | input | 1 | Transmission completed strobe |
| done_slot | input | 5 | Slot that completed |
| cancel_valid | input | 1 | Cancellation strobe |
| cancel_slot | input | 5 | Slot whose request is withdrawn |
| base_addr | input | 16 | Word address of slot 0 |
| elem_words | input | ESZ_W | Element size in 32-bit words |
| get_idx | output | 5 | Slot offered for transmission |
| put_idx | output | 5 | Next free slot |
| free_level | output | 6 | Number of free slots |
| fifo_full | output | 1 | No free slot |
| fifo_empty | output | 1 | No occupied slot |
| tx_valid | output | 1 | Slot at get_idx has a pending request |
| pend_vec | output | DEPTH | Pending bit per slot |
| overflow_err | output | 1 | Sticky add-overflow flag |
| free_addr | output | 16 | Word address of the slot at put_idx |

## Verification
A corrupted occupancy count shows up on the cycle after the faulty update. The free level and the full or empty flags then disagree with the number of adds minus releases, and fifo_full and fifo_empty can even rise together. A get index that skips the wrong distance appears at once on get_idx and tx_valid. It also puts the free level off by the same amount. Pending bits that are lost or never set hold tx_valid low at the head of the ring, and a search over stale bits stops the skip at a slot that was already withdrawn. Both faults show within one cycle of the completion or cancel that exposes them.

// File: rtl/txr_pkg.sv
package txr_pkg;

  localparam int IDX_W = 5;
  localparam int CNT_W = 6;
  localparam int SLOTS = 32;

  // (a + b) mod depth, with a < depth and b <= depth
  function automatic logic [IDX_W-1:0] ring_add(input logic [IDX_W-1:0] a,
                                                 input logic [CNT_W-1:0] b,
                                                 input logic [CNT_W-1:0] depth);
    logic [CNT_W:0] s;
    s = {2'b00, a} + {1'b0, b};
    if (s >= {1'b0, depth}) s = s - {1'b0, depth};
    return s[IDX_W-1:0];
  endfunction

  // (a - b) mod depth, with a, b < depth
  function automatic logic [CNT_W-1:0] ring_sub(input logic [IDX_W-1:0] a,
                                                 input logic [IDX_W-1:0] b,
                                                 input logic [CNT_W-1:0] depth);
    logic [CNT_W:0] s;
    s = {2'b00, a} + {1'b0, depth} - {2'b00, b};
    if (s >= {1'b0, depth}) s = s - {1'b0, depth};
    return s[CNT_W-1:0];
  endfunction

endpackage

// File: rtl/txr_rst_sync.sv
module txr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/txr_pend_vec.sv
module txr_pend_vec
  import txr_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_base,
  input  logic [CNT_W-1:0] set_cnt,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_slot,
  output logic [SLOTS-1:0] pend_q,
  output logic [SLOTS-1:0] live
);

  localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);

  logic [SLOTS-1:0] pend_d;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < DEPTH) begin : g_used
      logic             hit_clr;
      logic             hit_set;
      logic [CNT_W-1:0] ofs;
      always_comb begin
        ofs       = ring_sub(IDX_W'(s), set_base, DEPTH_V);
        hit_clr   = clr_en && (clr_slot == IDX_W'(s));
        hit_set   = set_en && (ofs < set_cnt);
        live[s]   = pend_q[s] & ~hit_clr;
        pend_d[s] = hit_set | live[s];
      end
    end else begin : g_unused
      assign live[s]   = 1'b0;
      assign pend_d[s] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/txr_skip.sv
module txr_skip
  import txr_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic [IDX_W-1:0] get_idx,
  input  logic [CNT_W-1:0] used,
  input  logic [SLOTS-1:0] live,
  output logic [CNT_W-1:0] step
);

  localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);

  // nearest pending slot after the head inside the occupied region;
  // with none left the head moves to the put index (step = used)
  always_comb begin
    step = used;
    for (int k = DEPTH - 1; k >= 1; k--) begin
      if ((CNT_W'(k) < used) && live[ring_add(get_idx, CNT_W'(k), DEPTH_V)])
        step = CNT_W'(k);
    end
  end

endmodule

// File: rtl/txr_addr.sv
module txr_addr
  import txr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ESZ_W  = 6
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ESZ_W-1:0]  elem_words,
  input  logic [IDX_W-1:0]  slot,
  output logic [ADDR_W-1:0] word_addr
);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset    = ADDR_W'(slot) * ADDR_W'(elem_words);
    word_addr = base_addr + offset;
  end

endmodule

// File: rtl/txr_index_mgr.sv
module txr_index_mgr
  import txr_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ESZ_W  = 6,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              queue_mode,
  input  logic              add_valid,
  input  logic [5:0]        add_count,
  input  logic              done_valid,
  input  logic [4:0]        done_slot,
  input  logic              cancel_valid,
  input  logic [4:0]        cancel_slot,
  input  logic [15:0]       base_addr,
  input  logic [ESZ_W-1:0]  elem_words,
  output logic [4:0]        get_idx,
  output logic [4:0]        put_idx,
  output logic [5:0]        free_level,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              tx_valid,
  output logic [DEPTH-1:0]  pend_vec,
  output logic              overflow_err,
  output logic [15:0]       free_addr
);

  localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);

  logic             rst_n_s;
  logic [IDX_W-1:0] get_q, get_d;
  logic [IDX_W-1:0] put_q, put_d;
  logic [CNT_W-1:0] used_q, used_d;
  logic             ovf_q;
  logic             idx_en, ovf_en;

  logic             act, add_req, add_ok, add_bad;
  logic             done_hit, cncl_any, cncl_hit, adv;
  logic             clr_en;
  logic [IDX_W-1:0] clr_slot;
  logic [CNT_W-1:0] free_now, step, rel_cnt, add_cnt;
  logic [SLOTS-1:0] pend_all, live;

  txr_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  txr_pend_vec #(.DEPTH(DEPTH)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .set_en   (add_ok),
    .set_base (put_q),
    .set_cnt  (add_count),
    .clr_en   (clr_en),
    .clr_slot (clr_slot),
    .pend_q   (pend_all),
    .live     (live)
  );

  txr_skip #(.DEPTH(DEPTH)) u_skip (
    .get_idx (get_q),
    .used    (used_q),
    .live    (live),
    .step    (step)
  );

  txr_addr #(.ADDR_W(ADDR_W), .ESZ_W(ESZ_W)) u_addr (
    .base_addr  (base_addr),
    .elem_words (elem_words),
    .slot       (put_q),
    .word_addr  (free_addr)
  );

  // event decode
  always_comb begin
    act      = !queue_mode;
    free_now = DEPTH_V - used_q;
    add_req  = act && add_valid && (add_count != '0);
    add_ok   = add_req && (add_count <= free_now);
    add_bad  = add_req && !add_ok;
    done_hit = act && done_valid && (done_slot == get_q) && pend_all[get_q];
    cncl_any = act && cancel_valid && !done_valid;
    cncl_hit = cncl_any && (cancel_slot == get_q) && pend_all[get_q];
    adv      = done_hit || cncl_hit;
    clr_en   = done_hit || cncl_any;
    clr_slot = done_hit ? done_slot : cancel_slot;
  end

  // next state
  always_comb begin
    rel_cnt = adv ? step : '0;
    add_cnt = add_ok ? add_count : '0;
    used_d  = used_q - rel_cnt + add_cnt;
    get_d   = adv ? ring_add(get_q, step, DEPTH_V) : get_q;
    put_d   = add_ok ? ring_add(put_q, add_count, DEPTH_V) : put_q;
    idx_en  = adv || add_ok;
    ovf_en  = add_bad;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      get_q  <= '0;
      put_q  <= '0;
      used_q <= '0;
    end else if (idx_en) begin
      get_q  <= get_d;
      put_q  <= put_d;
      used_q <= used_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    ovf_q <= 1'b0;
    else if (ovf_en) ovf_q <= 1'b1;
  end

  always_comb begin
    get_idx      = get_q;
    put_idx      = put_q;
    free_level   = free_now;
    fifo_full    = (used_q == DEPTH_V);
    fifo_empty   = (used_q == '0);
    tx_valid     = act && pend_all[get_q];
    pend_vec     = pend_all[DEPTH-1:0];
    overflow_err = ovf_q;
  end

endmodule

// File: rtl/txr_index_mgr_chk.sv
module txr_index_mgr_chk #(
  parameter int DEPTH = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       queue_mode,
  input logic       add_valid,
  input logic [5:0] add_count,
  input logic       done_valid,
  input logic       cancel_valid,
  input logic [4:0] cancel_slot,
  input logic [4:0] get_idx,
  input logic [4:0] put_idx,
  input logic [5:0] free_level,
  input logic       fifo_full,
  input logic       fifo_empty,
  input logic       tx_valid,
  input logic       overflow_err
);

  localparam logic [5:0] DEPTH_V = 6'(DEPTH);

  AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty)); // R3

  AST_FREE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    free_level <= DEPTH_V); // R3

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err); // R8

  AST_OVERFLOW_PUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!queue_mode && add_valid && add_count > free_level) |=> $stable(put_idx)); // R8

  AST_ADD_LOWERS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!queue_mode && add_valid && add_count != 6'd0 && add_count <= free_level
     && !done_valid && !cancel_valid)
    |=> free_level == $past(free_level) - $past(add_count)); // R2

  AST_OTHER_CANCEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!queue_mode && cancel_valid && !done_valid && cancel_slot != get_idx && !add_valid)
    |=> ($stable(get_idx) && $stable(free_level))); // R7

  AST_QMODE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    queue_mode |=> ($stable(get_idx) && $stable(put_idx) && $stable(free_level))); // R11

  AST_QMODE_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    queue_mode |-> !tx_valid); // R11

endmodule

bind txr_index_mgr txr_index_mgr_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .queue_mode   (queue_mode),
  .add_valid    (add_valid),
  .add_count    (add_count),
  .done_valid   (done_valid),
  .cancel_valid (cancel_valid),
  .cancel_slot  (cancel_slot),
  .get_idx      (get_idx),
  .put_idx      (put_idx),
  .free_level   (free_level),
  .fifo_full    (fifo_full),
  .fifo_empty   (fifo_empty),
  .tx_valid     (tx_valid),
  .overflow_err (overflow_err)
);

// File: tb/txr_index_mgr_test.sv
module txr_index_mgr_test;

  localparam int D = 8;

  typedef struct {
    logic [4:0]  get;
    logic [4:0]  put;
    logic [5:0]  free;
    logic        full;
    logic        empty;
    logic        txv;
    logic        ovf;
    logic [15:0] addr;
    logic [D-1:0] pend;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        queue_mode, add_valid, done_valid, cancel_valid;
  logic [5:0]  add_count;
  logic [4:0]  done_slot, cancel_slot;
  logic [15:0] base_addr;
  logic [5:0]  elem_words;
  logic [4:0]  get_idx, put_idx;
  logic [5:0]  free_level;
  logic        fifo_full, fifo_empty, tx_valid, overflow_err;
  logic [D-1:0] pend_vec;
  logic [15:0] free_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  exp_t exp_q[$];

  // reference state
  int          m_get, m_put, m_used;
  logic [D-1:0] m_pend;
  logic        m_ovf;

  always #4 clk = ~clk;

  txr_index_mgr #(.DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .queue_mode(queue_mode),
    .add_valid(add_valid), .add_count(add_count),
    .done_valid(done_valid), .done_slot(done_slot),
    .cancel_valid(cancel_valid), .cancel_slot(cancel_slot),
    .base_addr(base_addr), .elem_words(elem_words),
    .get_idx(get_idx), .put_idx(put_idx), .free_level(free_level),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .tx_valid(tx_valid),
    .pend_vec(pend_vec), .overflow_err(overflow_err), .free_addr(free_addr)
  );

  task automatic check(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // monitor: compare each expected item while outputs are stable
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, "get_idx",    int'(get_idx),      int'(e.get));
      check(e.tag, "put_idx",    int'(put_idx),      int'(e.put));
      check(e.tag, "free_level", int'(free_level),   int'(e.free));
      check(e.tag, "fifo_full",  int'(fifo_full),    int'(e.full));
      check(e.tag, "fifo_empty", int'(fifo_empty),   int'(e.empty));
      check(e.tag, "tx_valid",   int'(tx_valid),     int'(e.txv));
      check(e.tag, "overflow",   int'(overflow_err), int'(e.ovf));
      check(e.tag, "free_addr",  int'(free_addr),    int'(e.addr));
      check(e.tag, "pend_vec",   int'(pend_vec),     int'(e.pend));
    end
  end

  // driver: update the reference from the requirements, run one cycle, push expectation
  task automatic apply(input string tag);
    bit act, add_req, done_hit, cn_any, cn_hit;
    int step;
    logic [D-1:0] live;
    exp_t e;
    act      = !queue_mode;
    add_req  = act && add_valid && add_count != 0;
    done_hit = act && done_valid && int'(done_slot) == m_get && m_pend[m_get];
    cn_any   = act && cancel_valid && !done_valid;
    cn_hit   = cn_any && int'(cancel_slot) == m_get && m_pend[m_get];
    live = m_pend;
    if (done_hit) live[done_slot] = 1'b0;
    else if (cn_any && int'(cancel_slot) < D) live[cancel_slot] = 1'b0;
    step = 0;
    if (done_hit || cn_hit) begin
      step = m_used;
      for (int k = m_used - 1; k >= 1; k--)
        if (live[(m_get + k) % D]) step = k;
    end
    if (add_req && int'(add_count) > D - m_used) begin
      m_ovf = 1'b1;
    end else if (add_req) begin
      for (int k = 0; k < int'(add_count); k++) live[(m_put + k) % D] = 1'b1;
      m_put  = (m_put + int'(add_count)) % D;
      m_used = m_used + int'(add_count);
    end
    m_get  = (m_get + step) % D;
    m_used = m_used - step;
    m_pend = live;
    e.get   = 5'(m_get);
    e.put   = 5'(m_put);
    e.free  = 6'(D - m_used);
    e.full  = (m_used == D);
    e.empty = (m_used == 0);
    e.txv   = act && m_pend[m_get];
    e.ovf   = m_ovf;
    e.addr  = 16'(int'(base_addr) + m_put * int'(elem_words));
    e.pend  = m_pend;
    e.tag   = tag;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    @(negedge clk);
    #1;
    queue_mode = 1'b0; add_valid = 1'b0; done_valid = 1'b0; cancel_valid = 1'b0;
    add_count = '0;
  endtask

  task automatic do_add(input int n, input string tag);
    add_valid = 1'b1; add_count = 6'(n); apply(tag);
  endtask
  task automatic do_done(input int s, input string tag);
    done_valid = 1'b1; done_slot = 5'(s); apply(tag);
  endtask
  task automatic do_cancel(input int s, input string tag);
    cancel_valid = 1'b1; cancel_slot = 5'(s); apply(tag);
  endtask

  initial begin
    rst_n = 1'b0;
    queue_mode = 1'b0; add_valid = 1'b0; add_count = '0;
    done_valid = 1'b0; done_slot = '0; cancel_valid = 1'b0; cancel_slot = '0;
    base_addr = 16'h0100; elem_words = 6'd4;
    m_get = 0; m_put = 0; m_used = 0; m_pend = '0; m_ovf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    apply("R1 reset state");
    do_add(3, "R2 add three");                 // put 3, free 5, head pending (R4)
    do_done(0, "R5 head completes");           // get 1
    do_done(2, "R5 completion off head ignored");
    do_add(5, "R2 add wraps put");             // put 0, free 1
    do_add(2, "R8 add beyond free level");     // overflow, no change
    add_valid = 1'b1; add_count = 6'd1; done_valid = 1'b1; done_slot = 5'd1;
    apply("R9 add with completion");           // get 2, put 1, free 1
    do_add(1, "R3 ring becomes full");         // put 2 == get 2, full
    do_cancel(4, "R7 cancel behind head");
    do_cancel(2, "R6 cancel at head");         // get 3
    do_done(3, "R5 completion skips withdrawn slot"); // get 5
    queue_mode = 1'b1; add_valid = 1'b1; add_count = 6'd1; done_valid = 1'b1; done_slot = 5'd5;
    apply("R11 queue mode ignores events");
    done_valid = 1'b1; done_slot = 5'd5; cancel_valid = 1'b1; cancel_slot = 5'd6;
    apply("R12 completion wins over cancel");  // get 6
    do_cancel(6, "R6 cancel head again");      // get 7
    do_cancel(0, "R7 cancel other slot");
    do_cancel(1, "R7 cancel last other slot");
    do_cancel(7, "R6 cancel head none left");  // get = put = 2, empty (R3)
    base_addr = 16'hFFF0; elem_words = 6'd20;
    apply("R10 address wraps at 16 bits");
    do_add(4, "R4 head offered in add order");
    do_done(2, "R5 in-order completion");
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule